// File: doc/BRIEF.md
# Predicated Vector Carry-Chain Adder

This block adds or subtracts two 128-bit vectors split into four 32-bit lanes, passing a single carry from lane to lane in ascending order so that the four lanes together act as one wide add or subtract. The carry that enters lane 0 is either a constant chosen by the operation or the C bit of an incoming NZCV flag nibble. Lane 3's carry-out returns as the new C flag.

A 16-bit predicate with one bit per byte selects which destination bytes take the new sum and which keep their previous value. The bit for a lane's lowest byte decides whether that lane takes part in the carry chain. A skip-first-beat input makes the fixed-carry variant take its starting carry from the flag, as the flag-carry variant does.

Operands arrive on a valid/ready input stream. The merged vector and the flags leave on a valid/ready output stream through a single register stage. The input is accepted while the output register is empty or being drained, so `in_ready = !out_valid || out_ready`. A result that is held back stays stable until it is taken.

Top module: `vec_carry_adder`

## Requirements
- R1: In add mode (`in_sub`=0), each lane's sum is `a + b + carry_in` modulo 2^32, and the lane carry-out is bit 32 of the 33-bit sum.
- R2: In subtract mode (`in_sub`=1), every bit of the lane's `b` is inverted before the add.
- R3: The carry-out of lane i is the carry-in of lane i+1. Lane i (bits 32i+31..32i) is active when predicate bit 4i is 1. An inactive lane passes its carry-in through unchanged.
- R4: When `in_fixed_carry`=1 and `in_skip_first`=0, the lane-0 carry is 0 for add and 1 for subtract. In every other case it is `in_flags[1]` (the C flag).
- R5: Destination byte k (bits 8k+7..8k) takes byte k of the lane sum when predicate bit k is 1. Otherwise it takes byte k of `in_dest_old`.
- R6: The flags are updated when at least one lane is active, or when `in_fixed_carry`=1 and `in_skip_first`=0. The NZCV bit order is N=3, Z=2, C=1, V=0. An update gives N=Z=V=0 and C equal to the final chain carry.
- R7: When no update happens, `out_flags` equals `in_flags`.
- R8: A transfer accepted on `in_valid && in_ready` appears on the outputs with `out_valid`=1 after the next rising edge. An active-low synchronous reset clears `out_valid`.
- R9: `in_ready` is `!out_valid || out_ready`. While `out_valid && !out_ready`, the outputs hold stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken |
| in_sub | input | 1 | 1 = subtract with carry, 0 = add with carry |
| in_fixed_carry | input | 1 | Use the constant starting carry |
| in_skip_first | input | 1 | First beat skipped; the constant carry is not used |
| in_pred | input | 16 | Per-byte predicate |
| in_opa | input | 128 | First operand vector |
| in_opb | input | 128 | Second operand vector |
| in_dest_old | input | 128 | Previous destination contents |
| in_flags | input | 4 | Current NZCV flags |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_dest | output | 128 | Merged destination vector |
| out_flags | output | 4 | Resulting NZCV flags |

## Verification
Operands that are all ones with a carry of one send a carry through all four lanes. This shows whether the chain links the lanes and whether the final C comes from lane 3. Predicates with an inactive middle lane show whether a held-off lane passes the carry through or drops it. Predicates with partly set byte groups show whether the byte merge is separate from lane activity. Fixed-carry inputs with and without the skip flag, taken against both settings of the incoming C, separate the constant seed from the flag seed and show when the flags update. Random operands, predicates and modes, fed while the consumer stalls at random, cover the rest and exercise back-pressure.

// File: rtl/vca_pkg.sv
package vca_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 32;
  localparam int BYTE_W = 8;
  localparam int FLG_N  = 3;
  localparam int FLG_Z  = 2;
  localparam int FLG_C  = 1;
  localparam int FLG_V  = 0;
  typedef logic [3:0] nzcv_t;
endpackage

// File: rtl/vca_carry_seed.sv
module vca_carry_seed (
  input  logic          sub,
  input  logic          fixed_carry,
  input  logic          skip_first,
  input  vca_pkg::nzcv_t flags,
  output logic          seed,
  output logic          forced_update
);
  logic use_const;
  always_comb begin
    use_const     = fixed_carry && !skip_first;
    seed          = use_const ? sub : flags[vca_pkg::FLG_C];
    forced_update = use_const;
  end
endmodule

// File: rtl/vca_lane.sv
module vca_lane #(
  parameter int W  = 32,
  parameter int BW = 8,
  localparam int NB = W / BW
) (
  input  logic          cin,
  input  logic          sub,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [W-1:0]  old,
  input  logic [NB-1:0] bmask,
  output logic          active,
  output logic          cout,
  output logic [W-1:0]  res
);
  logic [W:0] sum;
  always_comb begin
    sum    = {1'b0, a} + {1'b0, b ^ {W{sub}}} + {{W{1'b0}}, cin};
    active = bmask[0];
    cout   = active ? sum[W] : cin;
  end

  for (genvar j = 0; j < NB; j++) begin : g_byte
    assign res[j*BW +: BW] = bmask[j] ? sum[j*BW +: BW] : old[j*BW +: BW];
  end
endmodule

// File: rtl/vca_out_stage.sv
module vca_out_stage #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] d_in,
  input  vca_pkg::nzcv_t f_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] d_out,
  output vca_pkg::nzcv_t f_out
);
  logic load;
  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (load)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      d_out <= d_in;
      f_out <= f_in;
    end
  end
endmodule

// File: rtl/vec_carry_adder.sv
module vec_carry_adder #(
  parameter int LANES  = vca_pkg::LANES,
  parameter int LANE_W = vca_pkg::LANE_W,
  parameter int BYTE_W = vca_pkg::BYTE_W,
  localparam int BPL   = LANE_W / BYTE_W,
  localparam int VEC_W = LANES * LANE_W,
  localparam int MSK_W = LANES * BPL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sub,
  input  logic             in_fixed_carry,
  input  logic             in_skip_first,
  input  logic [MSK_W-1:0] in_pred,
  input  logic [VEC_W-1:0] in_opa,
  input  logic [VEC_W-1:0] in_opb,
  input  logic [VEC_W-1:0] in_dest_old,
  input  logic [3:0]       in_flags,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_dest,
  output logic [3:0]       out_flags
);
  logic [LANES:0]   chain;
  logic [LANES-1:0] lane_act;
  logic [VEC_W-1:0] merged;
  logic             forced_upd;
  vca_pkg::nzcv_t   next_flags;

  vca_carry_seed u_seed (
    .sub          (in_sub),
    .fixed_carry  (in_fixed_carry),
    .skip_first   (in_skip_first),
    .flags        (in_flags),
    .seed         (chain[0]),
    .forced_update(forced_upd)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vca_lane #(.W(LANE_W), .BW(BYTE_W)) u_lane (
      .cin   (chain[i]),
      .sub   (in_sub),
      .a     (in_opa[i*LANE_W +: LANE_W]),
      .b     (in_opb[i*LANE_W +: LANE_W]),
      .old   (in_dest_old[i*LANE_W +: LANE_W]),
      .bmask (in_pred[i*BPL +: BPL]),
      .active(lane_act[i]),
      .cout  (chain[i+1]),
      .res   (merged[i*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    if (forced_upd || (|lane_act)) begin
      next_flags = '0;
      next_flags[vca_pkg::FLG_C] = chain[LANES];
    end else begin
      next_flags = in_flags;
    end
  end

  vca_out_stage #(.DW(VEC_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d_in     (merged),
    .f_in     (next_flags),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .d_out    (out_dest),
    .f_out    (out_flags)
  );
endmodule

// File: rtl/vca_chk.sv
module vca_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_fixed_carry,
  input logic         in_skip_first,
  input logic [15:0]  in_pred,
  input logic [127:0] in_dest_old,
  input logic [3:0]   in_flags,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_dest,
  input logic [3:0]   out_flags
);
  logic fire;
  logic idle_lanes;
  assign fire       = in_valid && in_ready;
  assign idle_lanes = !(in_pred[0] || in_pred[4] || in_pred[8] || in_pred[12]);

  // R8
  reset_clears_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dest) && $stable(out_flags)));

  // R6
  fixed_clears_nzv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_fixed_carry && !in_skip_first) |=>
      (out_flags[3] == 1'b0 && out_flags[2] == 1'b0 && out_flags[0] == 1'b0));

  // R7
  no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && idle_lanes && !(in_fixed_carry && !in_skip_first)) |=>
      (out_flags == $past(in_flags)));

  // R5
  empty_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_pred == 16'h0) |=> (out_dest == $past(in_dest_old)));
endmodule

bind vec_carry_adder vca_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_fixed_carry(in_fixed_carry), .in_skip_first(in_skip_first),
  .in_pred(in_pred), .in_dest_old(in_dest_old), .in_flags(in_flags),
  .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest),
  .out_flags(out_flags)
);

// File: tb/vec_carry_adder_bench.sv
`timescale 1ns/1ps
module vec_carry_adder_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_sub = 1'b0, in_fixed_carry = 1'b0, in_skip_first = 1'b0;
  logic [15:0]  in_pred = '0;
  logic [127:0] in_opa = '0, in_opb = '0, in_dest_old = '0;
  logic [3:0]   in_flags = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_dest;
  logic [3:0]   out_flags;

  int tests = 0, fails = 0;
  bit stall_en = 1'b0;
  logic [127:0] exp_d_q[$];
  logic [3:0]   exp_f_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  vec_carry_adder u_vec_carry_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sub(in_sub), .in_fixed_carry(in_fixed_carry), .in_skip_first(in_skip_first),
    .in_pred(in_pred), .in_opa(in_opa), .in_opb(in_opb), .in_dest_old(in_dest_old),
    .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_dest(out_dest), .out_flags(out_flags)
  );

  function automatic void ref_model(
    input logic sub, fixed, skip, input logic [15:0] p,
    input logic [127:0] a, b, old, input logic [3:0] fl,
    output logic [127:0] d, output logic [3:0] fo);
    logic c, upd;
    logic [32:0] s;
    c   = (fixed && !skip) ? sub : fl[1];
    upd = fixed && !skip;
    for (int i = 0; i < 4; i++) begin
      s = {1'b0, a[i*32 +: 32]} + {1'b0, b[i*32 +: 32] ^ {32{sub}}} + {32'd0, c};
      if (p[4*i]) begin
        c   = s[32];
        upd = 1'b1;
      end
      for (int j = 0; j < 4; j++)
        d[i*32 + j*8 +: 8] = p[4*i+j] ? s[j*8 +: 8] : old[i*32 + j*8 +: 8];
    end
    fo = upd ? {2'b00, c, 1'b0} : fl;
  endfunction

  task automatic send(input logic sub, fixed, skip, input logic [15:0] p,
                      input logic [127:0] a, b, old, input logic [3:0] fl,
                      input string tag);
    logic [127:0] ed;
    logic [3:0]   ef;
    ref_model(sub, fixed, skip, p, a, b, old, fl, ed, ef);
    @(negedge clk);
    in_sub = sub; in_fixed_carry = fixed; in_skip_first = skip; in_pred = p;
    in_opa = a; in_opb = b; in_dest_old = old; in_flags = fl; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_d_q.push_back(ed);
    exp_f_q.push_back(ef);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #2;
    out_ready = stall_en ? 1'($urandom % 2) : 1'b1;
  end

  logic         held = 1'b0;
  logic [127:0] held_d;
  logic [3:0]   held_f;
  always @(negedge clk) begin
    if (rst_n && held) begin
      tests++;
      if (!out_valid || out_dest !== held_d || out_flags !== held_f) begin
        fails++;
        $display("FAIL R9 stalled output changed: valid=%0b flags=%h exp flags=%h", out_valid, out_flags, held_f);
      end
    end
    held   = rst_n && out_valid && !out_ready;
    held_d = out_dest;
    held_f = out_flags;
    if (rst_n && out_valid && out_ready) begin
      if (exp_d_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R8 unexpected output: got %h exp none", out_dest);
      end else begin
        logic [127:0] ed;
        logic [3:0]   ef;
        string        tg;
        ed = exp_d_q.pop_front();
        ef = exp_f_q.pop_front();
        tg = tag_q.pop_front();
        tests++;
        if (out_dest !== ed || out_flags !== ef) begin
          fails++;
          $display("FAIL %s dest=%h flags=%h exp dest=%h flags=%h", tg, out_dest, out_flags, ed, ef);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired: got hang exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [127:0] ONES = {128{1'b1}};
  localparam logic [127:0] OLD  = {4{32'hA5A5_5A5A}};

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R8 reset state: valid=%b ready=%b exp 0/1", out_valid, in_ready);
    end
    rst_n = 1'b1;

    // Ripple through all lanes: all ones + 0 + carry from flag
    send(0, 0, 0, 16'hFFFF, ONES, '0, OLD, 4'b1111, "R1 R3 R6 full ripple add");
    // Fixed carry add seeds 0: no ripple
    send(0, 1, 0, 16'hFFFF, ONES, '0, OLD, 4'b0010, "R4 R1 fixed add seed 0");
    // Fixed carry subtract of equal operands seeds 1
    send(1, 1, 0, 16'hFFFF, {4{32'h1234_5678}}, {4{32'h1234_5678}}, OLD, 4'b0000, "R2 R4 fixed sub");
    // Skip-first: fixed variant uses flag C
    send(1, 1, 1, 16'hFFFF, {4{32'h10}}, {4{32'h10}}, OLD, 4'b0000, "R4 skip uses flag C=0");
    send(0, 1, 1, 16'hFFFF, ONES, '0, OLD, 4'b0010, "R4 skip uses flag C=1");
    // Inactive middle lane passes the carry on
    send(0, 0, 0, 16'hF0FF, ONES, '0, OLD, 4'b0010, "R3 inactive lane 2 carry pass");
    // Partial byte groups: lane 0 inactive but bytes 1,2 written
    send(0, 0, 0, 16'h0006, {4{32'h0101_0101}}, {4{32'h0202_0202}}, OLD, 4'b1011, "R5 R7 partial bytes no update");
    // Empty predicate, flag variant: everything unchanged
    send(1, 0, 0, 16'h0000, ONES, ONES, OLD, 4'b1101, "R5 R7 empty predicate");
    // Empty predicate, fixed variant: flags still update
    send(1, 1, 0, 16'h0000, ONES, '0, OLD, 4'b1111, "R6 fixed forces update");
    // Empty predicate, fixed with skip: no update
    send(0, 1, 1, 16'h0000, ONES, ONES, OLD, 4'b0101, "R7 skip no update");

    stall_en = 1'b1;
    for (int k = 0; k < 80; k++) begin
      send(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
           {$urandom, $urandom, $urandom, $urandom},
           (k % 5 == 0) ? ONES : {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, 4'($urandom),
           "R1 R2 R3 R5 R6 R9 random");
    end
    stall_en = 1'b0;
    repeat (10) @(negedge clk);
    tests++;
    if (exp_d_q.size() != 0) begin
      fails++;
      $display("FAIL R8 results missing: got %0d pending exp 0", exp_d_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule